// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Prescaler

This block makes the serial clock for an SPI master from the main clock. Two stages are chained. A coarse stage divides the main clock by 2, 4, 8 or 16, chosen by a 2-bit coarse field. A fine stage divides that intermediate clock by 2*(F+1), where F is a 6-bit fine field. The resulting serial clock runs at main / ((2 << coarse) * 2 * (F+1)).

A sequential solver chooses the two fields. It takes the main clock frequency and the wanted serial rate in hertz. It forms the integer ratio Q = floor(main / rate) with an iterative restoring divider, which produces one quotient bit per cycle. It then tries the coarse settings from the lowest to the highest. At each setting it computes F+1 = floor(Q / (4 << coarse)) and keeps the first setting for which F+1 is no larger than 64. A request that is too fast clamps to the fastest pair. A request that is too slow clamps to the slowest pair. A request outside the reachable range also raises an error flag. The solver result feeds the clock generator. The generator takes new settings only while its enable is low. While disabled, it holds the serial clock at the idle level chosen by the polarity input. While running, it emits one-cycle strobes on the leading and trailing serial clock edges.

Top module: `spi_presc_top`

## Requirements
- R1: For a nonzero rate, with Q = floor(main/rate), the solver returns the lowest coarse value d in 0..3 for which floor(Q/(4<<d)) is at most 64. The fine value it returns is floor(Q/(4<<d)) - 1.
- R2: If floor(Q/4) is below 5 (the request is too fast), the solver returns coarse 0 and fine 4.
- R3: If no coarse value in 0..3 meets the bound of R1 (the request is too slow), the solver returns coarse 3 and fine 63. Every fine value the solver returns lies in 4..63.
- R4: The error flag is high exactly when Q < 20 or Q >= 2049. A rate of zero counts as an infinite Q: the flag is set, and the result is coarse 3, fine 63.
- R5: `solve_done` is high for a single cycle per accepted start. The result ports and the error flag hold their values until the next `solve_done`. A start pulse that arrives while a solve is in progress is ignored.
- R6: While `sclk_en` is high, `sclk` toggles every H = (2<<coarse)*(fine+1) main clock cycles. The first toggle comes H cycles after the first cycle in which the enable is sampled high.
- R7: While `sclk_en` is low, `sclk` settles one cycle later to the value sampled on `cpol`, and both edge strobes stay low.
- R8: Coarse and fine values that change while `sclk_en` is high do not alter the running period. The generator picks them up only while the enable is low.
- R9: `lead_tick` is high for the one cycle in which `sclk` has just left its idle level. `trail_tick` is high for the one cycle in which `sclk` has just returned to it. The two strobes are never high together.
- R10: After reset, the coarse field is 0, the fine field is 4, `solve_done` and `solve_err` are 0, and `sclk` is 0 with no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| solve_start | input | 1 | Starts a solve when the solver is idle |
| main_hz | input | 32 | Main clock frequency in Hz |
| speed_hz | input | 32 | Requested serial rate in Hz |
| solve_done | output | 1 | One-cycle pulse when a result is ready |
| solve_err | output | 1 | Requested rate is out of range |
| cfg_div | output | 2 | Resolved coarse prescale field |
| cfg_brg | output | 6 | Resolved fine divider field |
| sclk_en | input | 1 | Runs the serial clock when high |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_tick | output | 1 | Strobe on the edge leaving the idle level |
| trail_tick | output | 1 | Strobe on the edge returning to the idle level |

## Verification
The assertions assume two things about the inputs. First, `main_hz` and `speed_hz` stay valid for the cycle in which the solver accepts a start, because the divider captures them at that point. Second, the enable and polarity inputs are synchronous to `clk`. The stimulus meets both conditions by driving every input just after a rising edge and by holding the operands steady across each accepted start. The stimulus does send a second start during a busy solve, but with a different rate, so that an accepted start would show up in the result. Because the solver result can change while the clock is running, the bench also checks that the generator's period ignores the update until the enable drops.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    localparam int DIV_W      = 2;
    localparam int BRG_W      = 6;
    localparam int DIV_HI     = (1 << DIV_W) - 1;
    localparam int BRG_LO     = 4;
    localparam int BRG_HI     = (1 << BRG_W) - 1;
    localparam int BASE_SHIFT = 2;
    localparam int PC_W       = DIV_HI + 1;

    // Quotient bounds that define an out-of-range request
    localparam int FAST_Q = (BRG_LO + 1) << BASE_SHIFT;
    localparam int SLOW_Q = ((BRG_HI + 1) << (BASE_SHIFT + DIV_HI)) + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [BRG_W-1:0] brg;
    } presc_cfg_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DIVIDE,
        S_SEARCH
    } solve_state_e;

    function automatic presc_cfg_t cfg_reset();
        presc_cfg_t c;
        c.div = '0;
        c.brg = BRG_W'(BRG_LO);
        return c;
    endfunction

endpackage

// File: rtl/spi_presc_div.sv
module spi_presc_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem;
    logic [W-1:0]  q;
    logic [W-1:0]  d;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [W:0]    shifted;
    logic          ge;

    always_comb begin
        shifted = {rem[W-1:0], q[W-1]};
        ge      = shifted >= {1'b0, d};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            rem  <= '0;
            q    <= '0;
            d    <= '0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    rem  <= '0;
                    q    <= num;
                    d    <= den;
                    cnt  <= '0;
                end
            end else begin
                rem <= ge ? (shifted - {1'b0, d}) : shifted;
                q   <= {q[W-2:0], ge};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q;

    // R5: completion strobe of the divider is a single cycle
    p_div_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/spi_presc_solver.sv
module spi_presc_solver
    import spi_presc_pkg::*;
#(
    parameter int HZ_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [HZ_W-1:0] main_hz,
    input  logic [HZ_W-1:0] speed_hz,
    output logic            done,
    output logic            err,
    output presc_cfg_t      cfg
);
    solve_state_e     state;
    logic [DIV_W-1:0] idx;
    logic [HZ_W-1:0]  quot_q;
    logic [HZ_W-1:0]  dv_quot;
    logic             dv_done;
    logic             dv_start;
    logic [HZ_W-1:0]  cand;
    logic             too_fast;
    logic             fits;
    logic             last_idx;
    logic             range_err;

    assign dv_start = (state == S_IDLE) && start;

    spi_presc_div #(.W(HZ_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (dv_start),
        .num   (main_hz),
        .den   (speed_hz),
        .done  (dv_done),
        .quot  (dv_quot)
    );

    always_comb begin
        cand      = quot_q >> (BASE_SHIFT + int'(idx));
        too_fast  = cand < HZ_W'(BRG_LO + 1);
        fits      = cand <= HZ_W'(BRG_HI + 1);
        last_idx  = idx == DIV_W'(DIV_HI);
        range_err = (quot_q < HZ_W'(FAST_Q)) || (quot_q >= HZ_W'(SLOW_Q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            idx    <= '0;
            quot_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            cfg    <= cfg_reset();
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) state <= S_DIVIDE;
                end
                S_DIVIDE: begin
                    if (dv_done) begin
                        quot_q <= dv_quot;
                        idx    <= '0;
                        state  <= S_SEARCH;
                    end
                end
                S_SEARCH: begin
                    if (too_fast || fits || last_idx) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                        err   <= range_err;
                        if (too_fast) begin
                            cfg.div <= idx;
                            cfg.brg <= BRG_W'(BRG_LO);
                        end else if (fits) begin
                            cfg.div <= idx;
                            cfg.brg <= BRG_W'(cand - HZ_W'(1));
                        end else begin
                            cfg.div <= DIV_W'(DIV_HI);
                            cfg.brg <= BRG_W'(BRG_HI);
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R3: every reported fine value is inside the legal window
    p_brg_window_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (cfg.brg >= BRG_W'(BRG_LO)) && (cfg.brg <= BRG_W'(BRG_HI)));

    // R4: an out-of-range result is either the fast clamp or the slow clamp
    p_err_clamp_r4: assert property (@(posedge clk) disable iff (rst)
        (done && err && cfg.brg != BRG_W'(BRG_LO))
            |-> (cfg.div == DIV_W'(DIV_HI) && cfg.brg == BRG_W'(BRG_HI)));

    // R5: results hold between completions
    p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!done && $past(!rst)) |-> ($stable(cfg) && $stable(err)));

endmodule

// File: rtl/spi_presc_clkgen.sv
module spi_presc_clkgen
    import spi_presc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       cpol,
    input  presc_cfg_t cfg_in,
    output logic       sclk,
    output logic       lead_tick,
    output logic       trail_tick
);
    presc_cfg_t       shadow;
    logic             cpol_q;
    logic             ph;
    logic [PC_W-1:0]  pcnt;
    logic [BRG_W-1:0] bcnt;
    logic [PC_W:0]    pre_span;
    logic             pre_wrap;
    logic             fine_wrap;

    always_comb begin
        pre_span  = (PC_W + 1)'(2) << shadow.div;
        pre_wrap  = {1'b0, pcnt} == (pre_span - (PC_W + 1)'(1));
        fine_wrap = bcnt == shadow.brg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow     <= cfg_reset();
            cpol_q     <= 1'b0;
            ph         <= 1'b0;
            pcnt       <= '0;
            bcnt       <= '0;
            lead_tick  <= 1'b0;
            trail_tick <= 1'b0;
        end else if (!en) begin
            shadow     <= cfg_in;
            cpol_q     <= cpol;
            ph         <= 1'b0;
            pcnt       <= '0;
            bcnt       <= '0;
            lead_tick  <= 1'b0;
            trail_tick <= 1'b0;
        end else begin
            lead_tick  <= 1'b0;
            trail_tick <= 1'b0;
            if (pre_wrap) begin
                pcnt <= '0;
                if (fine_wrap) begin
                    bcnt       <= '0;
                    ph         <= ~ph;
                    lead_tick  <= ~ph;
                    trail_tick <= ph;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    assign sclk = ph ^ cpol_q;

    // R7: a held-off generator rests at the sampled polarity with no strobes
    p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
        (!en && $past(!en) && $past(!rst)) |-> (sclk == $past(cpol) && !lead_tick && !trail_tick));

    // R9: the two strobes never coincide
    p_tick_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(lead_tick && trail_tick));

    // R9: a strobe marks a cycle in which the serial clock has just moved
    p_tick_edge_r9: assert property (@(posedge clk) disable iff (rst)
        ((lead_tick || trail_tick) && $past(!rst)) |-> (sclk != $past(sclk)));

endmodule

// File: rtl/spi_presc_top.sv
module spi_presc_top
    import spi_presc_pkg::*;
#(
    parameter int HZ_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            solve_start,
    input  logic [HZ_W-1:0] main_hz,
    input  logic [HZ_W-1:0] speed_hz,
    output logic            solve_done,
    output logic            solve_err,
    output logic [DIV_W-1:0] cfg_div,
    output logic [BRG_W-1:0] cfg_brg,
    input  logic            sclk_en,
    input  logic            cpol,
    output logic            sclk,
    output logic            lead_tick,
    output logic            trail_tick
);
    presc_cfg_t solved;

    spi_presc_solver #(.HZ_W(HZ_W)) u_solver (
        .clk      (clk),
        .rst      (rst),
        .start    (solve_start),
        .main_hz  (main_hz),
        .speed_hz (speed_hz),
        .done     (solve_done),
        .err      (solve_err),
        .cfg      (solved)
    );

    spi_presc_clkgen u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .en         (sclk_en),
        .cpol       (cpol),
        .cfg_in     (solved),
        .sclk       (sclk),
        .lead_tick  (lead_tick),
        .trail_tick (trail_tick)
    );

    assign cfg_div = solved.div;
    assign cfg_brg = solved.brg;

endmodule

// File: tb/tb_spi_presc_top.sv
module tb_spi_presc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        solve_start = 1'b0;
    logic [31:0] main_hz = 32'd0;
    logic [31:0] speed_hz = 32'd0;
    logic        solve_done;
    logic        solve_err;
    logic [1:0]  cfg_div;
    logic [5:0]  cfg_brg;
    logic        sclk_en = 1'b0;
    logic        cpol = 1'b0;
    logic        sclk;
    logic        lead_tick;
    logic        trail_tick;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_presc_top dut (
        .clk        (clk),
        .rst        (rst),
        .solve_start(solve_start),
        .main_hz    (main_hz),
        .speed_hz   (speed_hz),
        .solve_done (solve_done),
        .solve_err  (solve_err),
        .cfg_div    (cfg_div),
        .cfg_brg    (cfg_brg),
        .sclk_en    (sclk_en),
        .cpol       (cpol),
        .sclk       (sclk),
        .lead_tick  (lead_tick),
        .trail_tick (trail_tick)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference of the serial clock, stepped at each falling edge
    bit     m_valid = 1'b0;
    bit     m_ph, m_lead, m_trail, m_cpol;
    int     m_cnt, m_half;
    string  clk_req = "R6";

    always @(negedge clk) begin
        if (m_valid && !finished) begin
            chk(sclk == (m_ph ^ m_cpol), sclk_en ? clk_req : "R7", "sclk",
                sclk, m_ph ^ m_cpol);
            chk(lead_tick == m_lead, "R9", "lead_tick", lead_tick, m_lead);
            chk(trail_tick == m_trail, "R9", "trail_tick", trail_tick, m_trail);
        end
        m_lead = 0;
        m_trail = 0;
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_cpol = 0; m_half = 2 * 5;
        end else if (!sclk_en) begin
            m_ph = 0; m_cnt = 0; m_cpol = cpol;
            m_half = (2 << cfg_div) * (cfg_brg + 1);
        end else begin
            m_cnt++;
            if (m_cnt == m_half) begin
                m_cnt = 0;
                m_ph = !m_ph;
                m_lead = m_ph;
                m_trail = !m_ph;
            end
        end
        m_valid = 1;
    end

    // Expected solver result computed from the requirement text
    task automatic expect_cfg(input longint m, input longint s,
                              output int d, output int b, output bit e);
        longint q, c;
        q = (s == 0) ? 64'hFFFF_FFFF : m / s;
        e = (q < 20) || (q >= 2049);
        d = 3; b = 63;
        for (int k = 0; k < 4; k++) begin
            c = q / (4 << k);
            if (c < 5) begin d = k; b = 4; break; end
            if (c <= 64) begin d = k; b = int'(c) - 1; break; end
        end
    endtask

    task automatic run_solve(input longint m, input longint s, input bit poke_busy,
                             input string req);
        int d, b;
        bit e;
        bit seen;
        expect_cfg(m, s, d, b, e);
        @(posedge clk); #1;
        main_hz = 32'(m); speed_hz = 32'(s); solve_start = 1;
        @(posedge clk); #1;
        solve_start = 0;
        if (poke_busy) begin
            // R5: a second start while busy, with a different rate
            speed_hz = 32'(s) + 32'd7;
            solve_start = 1;
            @(posedge clk); #1;
            solve_start = 0;
        end
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (solve_done) begin seen = 1; break; end
        end
        chk(seen, "R5", "done seen", seen, 1);
        chk(cfg_div == 2'(d), req, "coarse", cfg_div, d);
        chk(cfg_brg == 6'(b), req, "fine", cfg_brg, b);
        chk(solve_err == e, "R4", "err", solve_err, e);
        @(negedge clk);
        chk(solve_done == 0, "R5", "done width", solve_done, 0);
        repeat (3) @(negedge clk);
        chk(cfg_div == 2'(d) && cfg_brg == 6'(b), "R5", "hold",
            {cfg_div, cfg_brg}, {d[1:0], b[5:0]});
        if (poke_busy) begin
            // the ignored start must not launch another solve
            chk(solve_done == 0, "R5", "no extra done", solve_done, 0);
        end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R10: reset state
        chk(cfg_div == 0, "R10", "reset coarse", cfg_div, 0);
        chk(cfg_brg == 4, "R10", "reset fine", cfg_brg, 4);
        chk(solve_done == 0 && solve_err == 0, "R10", "reset flags",
            {solve_done, solve_err}, 0);
        chk(sclk == 0 && !lead_tick && !trail_tick, "R10", "reset clock",
            sclk, 0);

        run_solve(50_000_000, 1_000_000, 0, "R1");
        @(posedge clk); #1 sclk_en = 1;
        repeat (150) @(posedge clk);
        #1 sclk_en = 0;
        repeat (5) @(posedge clk);
        #1 cpol = 1;
        repeat (3) @(posedge clk);

        run_solve(50_000_000, 100_000, 1, "R1");
        @(posedge clk); #1 sclk_en = 1;
        repeat (600) @(posedge clk);
        #1 clk_req = "R8";
        run_solve(50_000_000, 10_000_000, 0, "R2");
        repeat (300) @(posedge clk);
        #1 sclk_en = 0; clk_req = "R6";
        repeat (5) @(posedge clk);
        #1 sclk_en = 1;
        repeat (100) @(posedge clk);
        #1 sclk_en = 0; cpol = 0;
        repeat (4) @(posedge clk);

        run_solve(50_000_000, 20_000, 0, "R3");
        run_solve(2_049_000, 1_000, 0, "R4");
        run_solve(2_048_000, 1_000, 0, "R1");
        run_solve(20_000, 1_000, 0, "R2");
        run_solve(19_000, 1_000, 0, "R2");
        run_solve(260_000, 1_000, 0, "R1");
        run_solve(50_000_000, 0, 0, "R4");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule